// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands of `DW` bits into a full `2*DW`-bit product and, in the same clock cycle, adds that product to, or subtracts it from, a signed accumulator. The accumulator is `2*DW + GUARD` bits wide. The `GUARD` extra bits hold the growth of a sum: summing `N` terms of width `w` needs `w + log2(N)` bits. With the defaults (`DW`=16, `GUARD`=8), 256 full-scale integer products fit without overflow.

A fractional-mode select doubles the product before it is accumulated. This removes the duplicated sign bit that a signed Q-format multiply produces. The accumulator never wraps around. A result above the top of its range is held at the most positive value, and a result below the bottom is held at the most negative value. Either case sets a sticky overflow flag.

A synchronous clear starts a new sum. Issued alone, it zeroes the accumulator. Issued with a valid input, it seeds the accumulator with the signed term of that input. The full accumulator is always visible. A high word, the upper half of the `2*DW`-bit product format, is derived from the accumulator once the sum is complete. That high word is rounded by default, or truncated when configured, and is clamped to `DW` bits.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_out` is 0, `hi_word` is 0 and `ovf_flag` is 0.
- R2: When `in_valid`=1, `sub_en`=0 and `clr`=0, the accumulator on the next clock equals its old value plus the signed product `op_a*op_b`. One operation completes per cycle.
- R3: When `in_valid`=1 and `sub_en`=1, the signed product is subtracted from the accumulator instead.
- R4: When `in_valid`=0 and `clr`=0, the operands, `sub_en` and `frac_en` have no effect, and `acc_out` and `ovf_flag` keep their values.
- R5: When `frac_en`=1, the product is shifted left by one bit (doubled) before it is added or subtracted. For example, -32768 times -32768 contributes 2^31.
- R6: When `clr`=1 and `in_valid`=0, the accumulator becomes 0 and `ovf_flag` becomes 0 on the next clock.
- R7: When `clr`=1 and `in_valid`=1, the accumulator is loaded with the term alone. The term is the product (doubled when `frac_en`=1), negated when `sub_en`=1. `ovf_flag` is cleared.
- R8: A result above 2^(AW-1)-1 leaves the accumulator at exactly 2^(AW-1)-1, where AW = 2*DW+GUARD (2^39-1 by default).
- R9: A result below -2^(AW-1) leaves the accumulator at exactly -2^(AW-1).
- R10: `ovf_flag` is set on the clock on which a saturation occurs. It stays set through later operations until a clear.
- R11: `hi_word` equals floor((acc + 2^(DW-1)) / 2^DW), which is round half up. It is clamped to the range -2^(DW-1) to 2^(DW-1)-1. It follows `acc_out` in the same cycle.
- R12: With `GUARD`=8, 256 integer-mode additions of (-32768)*(-32768) reach 2^38 with no saturation and `ovf_flag` still 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; the accumulator updates only when this is high (or on a clear) |
| op_a | input | DW | Signed multiplicand |
| op_b | input | DW | Signed multiplier |
| sub_en | input | 1 | 1 = subtract the term, 0 = add it |
| clr | input | 1 | Synchronous start of a new sum |
| frac_en | input | 1 | 1 = double the product (signed fractional mode) |
| acc_out | output | 2*DW+GUARD | Full signed accumulator |
| hi_word | output | DW | Rounded or truncated, clamped upper product half |
| ovf_flag | output | 1 | Sticky saturation indicator |

## Verification
A corrupted accumulator appears on `acc_out` in the cycle after the faulty update, and on `hi_word` in that same cycle. The bench therefore compares all three outputs against a behavioural model after every clock, so a fault is reported at the first step at which it exists. A lost or spurious overflow bit shows on `ovf_flag` one cycle after the saturating operation. It stays wrong until the next clear, which the long saturation runs expose. Guard-bit or sign-extension errors only appear near the range limits, so the bench drives full-scale products for hundreds of terms in both directions.

// File: rtl/sat_mac_pkg.sv
`timescale 1ns/1ps
package sat_mac_pkg;
    // Kind of update applied to the accumulator in a cycle
    typedef enum logic [1:0] {
        ACC_KEEP  = 2'd0,
        ACC_ZERO  = 2'd1,
        ACC_SEED  = 2'd2,
        ACC_STEP  = 2'd3
    } acc_op_e;
endpackage

// File: rtl/mac_term.sv
`timescale 1ns/1ps
// Signed multiply, optional doubling, optional negation
module mac_term #(
    parameter int DW = 16,
    localparam int PW = 2 * DW,
    localparam int TW = PW + 1
) (
    input  logic [DW-1:0]        a_i,
    input  logic [DW-1:0]        b_i,
    input  logic                 frac_i,
    input  logic                 neg_i,
    output logic signed [TW-1:0] term_o
);
    logic signed [PW-1:0] prod_w;
    logic signed [TW-1:0] wide_w;
    logic signed [TW-1:0] scaled_w;

    always_comb begin
        prod_w   = $signed(a_i) * $signed(b_i);
        wide_w   = {prod_w[PW-1], prod_w};
        scaled_w = frac_i ? (wide_w <<< 1) : wide_w;
        term_o   = neg_i ? -scaled_w : scaled_w;
    end
endmodule

// File: rtl/mac_sat_add.sv
`timescale 1ns/1ps
// Extended add with clamp to the accumulator range
module mac_sat_add #(
    parameter int AW = 40,
    parameter int TW = 33
) (
    input  logic signed [AW-1:0] base_i,
    input  logic signed [TW-1:0] term_i,
    output logic signed [AW-1:0] sum_o,
    output logic                 sat_o
);
    localparam int XW = AW + 1;
    localparam logic signed [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

    logic signed [XW-1:0] base_x;
    logic signed [XW-1:0] term_x;
    logic signed [XW-1:0] raw_x;

    always_comb begin
        base_x = {base_i[AW-1], base_i};
        term_x = {{(XW-TW){term_i[TW-1]}}, term_i};
        raw_x  = base_x + term_x;
        sat_o  = raw_x[XW-1] ^ raw_x[XW-2];
        if (!sat_o)
            sum_o = raw_x[AW-1:0];
        else if (raw_x[XW-1])
            sum_o = NEG_LIM;
        else
            sum_o = POS_LIM;
    end
endmodule

// File: rtl/mac_hiword.sv
`timescale 1ns/1ps
// Upper product half of the accumulator, rounded or truncated, clamped
module mac_hiword #(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter bit ROUND = 1'b1
) (
    input  logic signed [AW-1:0] acc_i,
    output logic [DW-1:0]        hi_o
);
    localparam int XW = AW + 1;
    localparam int SW = XW - DW;

    logic signed [XW-1:0] biased_w;
    logic signed [SW-1:0] top_w;
    logic [SW-DW:0]       sign_run_w;

    generate
        if (ROUND) begin : g_round
            always_comb biased_w = {acc_i[AW-1], acc_i} + (XW'(1) <<< (DW - 1));
        end else begin : g_trunc
            always_comb biased_w = {acc_i[AW-1], acc_i};
        end
    endgenerate

    always_comb begin
        top_w      = biased_w[XW-1:DW];
        sign_run_w = top_w[SW-1:DW-1];
        if ((&sign_run_w) || !(|sign_run_w))
            hi_o = top_w[DW-1:0];
        else if (top_w[SW-1])
            hi_o = {1'b1, {(DW-1){1'b0}}};
        else
            hi_o = {1'b0, {(DW-1){1'b1}}};
    end
endmodule

// File: rtl/sat_mac.sv
`timescale 1ns/1ps
module sat_mac
    import sat_mac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8,
    parameter bit ROUND = 1'b1,
    localparam int AW   = 2 * DW + GUARD,
    localparam int TW   = 2 * DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          sub_en,
    input  logic          clr,
    input  logic          frac_en,
    output logic [AW-1:0] acc_out,
    output logic [DW-1:0] hi_word,
    output logic          ovf_flag
);
    localparam logic signed [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic                 ovf;
    } mac_state_t;

    mac_state_t st_d, st_q;
    acc_op_e    op_d;

    logic signed [TW-1:0] term_w;
    logic signed [AW-1:0] base_w;
    logic signed [AW-1:0] sum_w;
    logic                 sat_w;

    mac_term #(.DW(DW)) u_term (
        .a_i    (op_a),
        .b_i    (op_b),
        .frac_i (frac_en),
        .neg_i  (sub_en),
        .term_o (term_w)
    );

    mac_sat_add #(.AW(AW), .TW(TW)) u_add (
        .base_i (base_w),
        .term_i (term_w),
        .sum_o  (sum_w),
        .sat_o  (sat_w)
    );

    mac_hiword #(.DW(DW), .AW(AW), .ROUND(ROUND)) u_hi (
        .acc_i (st_q.acc),
        .hi_o  (hi_word)
    );

    always_comb begin
        if (in_valid)
            op_d = clr ? ACC_SEED : ACC_STEP;
        else
            op_d = clr ? ACC_ZERO : ACC_KEEP;

        base_w = (op_d == ACC_SEED) ? '0 : st_q.acc;
        st_d   = st_q;
        unique case (op_d)
            ACC_ZERO: begin
                st_d.acc = '0;
                st_d.ovf = 1'b0;
            end
            ACC_SEED: begin
                st_d.acc = sum_w;
                st_d.ovf = sat_w;
            end
            ACC_STEP: begin
                st_d.acc = sum_w;
                st_d.ovf = st_q.ovf | sat_w;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_out  = st_q.acc;
    assign ovf_flag = st_q.ovf;

    // R4: idle cycles leave the accumulator untouched
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> ($stable(acc_out) && $stable(ovf_flag)));

    // R6: a lone clear empties the sum and the flag
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> (acc_out == '0 && !ovf_flag));

    // R10: the flag only drops after a clear
    assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag);

    // R8/R9: a new overflow leaves the accumulator on a range limit
    assert_clamp_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($signed(acc_out) == POS_LIM || $signed(acc_out) == NEG_LIM));

    // R11: a negative sum never yields a positive high word
    assert_hi_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_out[AW-1] |-> (hi_word[DW-1] || hi_word == '0));
endmodule

// File: tb/sim_sat_mac.sv
`timescale 1ns/1ps
module sim_sat_mac;
    localparam int DW = 16;
    localparam int GUARD = 8;
    localparam int AW = 2 * DW + GUARD;
    localparam longint POS_LIM = (longint'(1) <<< (AW - 1)) - 1;
    localparam longint NEG_LIM = -(longint'(1) <<< (AW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, sub_en = 1'b0, clr = 1'b0, frac_en = 1'b0;
    logic [DW-1:0] op_a = '0, op_b = '0;
    logic [AW-1:0] acc_out;
    logic [DW-1:0] hi_word;
    logic ovf_flag;

    int checks = 0;
    int failures = 0;
    longint m_acc = 0;
    bit m_ovf = 1'b0;

    always #5 clk = ~clk;

    sat_mac #(.DW(DW), .GUARD(GUARD)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .clr(clr), .frac_en(frac_en),
        .acc_out(acc_out), .hi_word(hi_word), .ovf_flag(ovf_flag)
    );

    function automatic longint model_hi(longint acc);
        longint r;
        r = (acc + 32768) >>> DW;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic compare(string tag);
        longint got_acc, exp_hi, got_hi;
        got_acc = longint'($signed(acc_out));
        got_hi  = longint'($signed(hi_word));
        exp_hi  = model_hi(m_acc);
        checks += 3;
        if (got_acc != m_acc) begin
            failures++;
            $display("FAIL %s acc actual=%0d expected=%0d", tag, got_acc, m_acc);
        end
        if (got_hi != exp_hi) begin
            failures++;
            $display("FAIL %s/R11 hi_word actual=%0d expected=%0d", tag, got_hi, exp_hi);
        end
        if (ovf_flag != m_ovf) begin
            failures++;
            $display("FAIL %s ovf actual=%0d expected=%0d", tag, ovf_flag, m_ovf);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, check after it
    task automatic step(bit v, int a, int b, bit s, bit c, bit f, string tag);
        longint t, sum;
        @(negedge clk);
        in_valid = v; op_a = DW'(a); op_b = DW'(b); sub_en = s; clr = c; frac_en = f;
        @(posedge clk);
        #2;
        if (v) begin
            t = longint'(a) * longint'(b);
            if (f) t = t * 2;
            if (s) t = -t;
            sum = (c ? 0 : m_acc) + t;
            if (c) m_ovf = 1'b0;
            if (sum > POS_LIM) begin sum = POS_LIM; m_ovf = 1'b1; end
            if (sum < NEG_LIM) begin sum = NEG_LIM; m_ovf = 1'b1; end
            m_acc = sum;
        end else if (c) begin
            m_acc = 0; m_ovf = 1'b0;
        end
        compare(tag);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare("R1");
        @(negedge clk); rst_n = 1'b1;
        #1; compare("R1");

        // R2 add, R3 subtract, integer mode
        step(1, 3, 4, 0, 0, 0, "R2");
        step(1, -5, 7, 0, 0, 0, "R2");
        step(1, -32768, -32768, 0, 0, 0, "R2");
        step(1, 100, -200, 1, 0, 0, "R3");
        step(1, -32768, 32767, 1, 0, 0, "R3");
        // R4 idle cycles with busy operands
        step(0, 1234, -999, 0, 0, 1, "R4");
        step(0, -32768, -32768, 1, 0, 0, "R4");
        // R5 fractional doubling
        step(1, 16384, 16384, 0, 0, 1, "R5");
        step(1, -32768, -32768, 1, 0, 1, "R5");
        // R6 lone clear, R7 seeded clear
        step(1, 7, 9, 0, 1, 0, "R7");
        step(0, 5, 5, 0, 1, 0, "R6");
        step(1, 300, 11, 1, 1, 1, "R7");
        // R11 rounding edges
        step(1, 1, 16384, 0, 1, 0, "R11");
        step(1, 1, 16384, 0, 0, 0, "R11");
        step(1, 1, 16383, 1, 1, 0, "R11");
        // R12 guard bits: 256 full-scale integer terms without overflow
        step(0, 0, 0, 0, 1, 0, "R6");
        for (int i = 0; i < 256; i++) step(1, -32768, -32768, 0, 0, 0, "R12");
        // R8 positive clamp: 256 doubled terms exceed the range
        step(0, 0, 0, 0, 1, 0, "R6");
        for (int i = 0; i < 256; i++) step(1, -32768, -32768, 0, 0, 1, "R8");
        step(1, -32768, -32768, 0, 0, 1, "R8");
        // R10 sticky through subtract and idle
        step(1, 10, 10, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        step(1, 2, 3, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        // R9 negative clamp
        for (int i = 0; i < 257; i++) step(1, -32768, -32768, 1, 0, 1, "R9");
        step(1, 1, 1, 1, 0, 0, "R9");
        step(1, 4, 4, 0, 1, 0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule